// File: doc/BRIEF.md
# Dual Cascaded Line Delay Memory

This block keeps two line stores of equal depth and turns one incoming pixel stream into two delayed copies. Bytes are stored on a write clock into the first store. On an independent read clock the block reads both stores at the same time. The byte it takes from the first store comes out as the one-line-delayed output. That same byte is also copied into the second store, so the second store returns it one line later as the two-line-delayed output.

Line length is set only by how far apart the write-reset and read-reset pulses are. Every address wraps at the store depth, so any line from two words up to the full depth works. Each output has a valid flag in place of three-state drive. The flag is high only after a read edge that actually delivered data.

Top module: `lm_dual_line_delay`

## Requirements
- R1: With `wen_n` low and `wres_n` high, each rising `wclk` edge stores `din` into the first store at the write address, and the write address then advances by one.
- R2: With `wen_n` high and `wres_n` high, a `wclk` edge stores nothing and the write address holds. Data offered then never appears on `q1`.
- R3: With `wres_n` low, a `wclk` edge sets the write address to 0 and stores nothing, whatever `wen_n` is. The next stored byte goes to address 0, and words at higher addresses are kept.
- R4: With `ren_n` low and `rres_n` high, a rising `rclk` edge loads `q1` from the first store and `q2` from the second store, both at the shared read address. It sets `q1_oe` and `q2_oe` to 1, and the read address then advances by one.
- R5: Each byte put on `q1` is written into the second store at the address it was read from. When the line is read again, `q2` returns that byte, provided the line is at least 2 words long.
- R6: With `ren_n` high and `rres_n` high, an `rclk` edge clears `q1_oe` and `q2_oe`, holds the read address, and copies nothing into the second store.
- R7: With `rres_n` low, an `rclk` edge sets the read address and the second-store write address to 0, clears both valid flags and performs no read, whatever `ren_n` is.
- R8: The write and read addresses wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wen_n | input | 1 | Write enable, active low |
| wres_n | input | 1 | Synchronous write-address reset, active low |
| din | input | WIDTH | Incoming pixel byte |
| rclk | input | 1 | Read-side clock, unrelated to `wclk` |
| ren_n | input | 1 | Read enable, active low |
| rres_n | input | 1 | Synchronous read-address reset, active low |
| q1 | output | WIDTH | One-line-delayed data |
| q1_oe | output | 1 | `q1` holds data from the latest read edge |
| q2 | output | WIDTH | Two-line-delayed data |
| q2_oe | output | 1 | `q2` holds data from the latest read edge |

## Verification
A write address that moves when it should not puts the fault into the first store. It shows on `q1` only on the next pass of the read side over that line, so checks read back full lines after each write pattern. A read address off by one shifts `q1` right away at the first read after read reset. A fault in the copy path can only be seen a full line later on `q2`, so every line scenario reads at least two consecutive lines. A wrong valid flag shows one read-clock edge after the enable changes.

// File: rtl/lm_pkg.sv
package lm_pkg;

  // Address step with wrap at the store depth.
  function automatic int unsigned lm_next_addr(input int unsigned a,
                                               input int unsigned depth);
    return (a >= depth - 1) ? 0 : a + 1;
  endfunction

endpackage

// File: rtl/lm_addr_ctr.sv
module lm_addr_ctr
  import lm_pkg::*;
#(
  parameter int unsigned DEPTH = 5120,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (clr)       ptr <= '0;
    else if (step) ptr <= AW'(lm_next_addr(32'(ptr), DEPTH));
  end

endmodule

// File: rtl/lm_sdp_ram.sv
module lm_sdp_ram #(
  parameter int unsigned DEPTH = 5120,
  parameter int unsigned WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/lm_copy_stage.sv
module lm_copy_stage #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          step,
  input  logic [AW-1:0] rd_addr,
  output logic          we,
  output logic [AW-1:0] waddr
);

  // The byte read at rd_addr lands in the output register on this edge;
  // it is written back into the second store on the next edge.
  always_ff @(posedge clk) begin
    we <= step;
    if (step) waddr <= rd_addr;
  end

endmodule

// File: rtl/lm_dual_line_delay.sv
module lm_dual_line_delay #(
  parameter int unsigned DEPTH = 5120,
  parameter int unsigned WIDTH = 8
) (
  input  logic             wclk,
  input  logic             wen_n,
  input  logic             wres_n,
  input  logic [WIDTH-1:0] din,
  input  logic             rclk,
  input  logic             ren_n,
  input  logic             rres_n,
  output logic [WIDTH-1:0] q1,
  output logic             q1_oe,
  output logic [WIDTH-1:0] q2,
  output logic             q2_oe
);

  localparam int AW = $clog2(DEPTH);

  // Named events, used by the checker.
  logic          w_clr, w_step, r_clr, r_step;
  logic [AW-1:0] w_ptr, r1_ptr, r2_ptr, copy_addr;
  logic          copy_we;
  logic          out_vld;

  assign w_clr  = !wres_n;
  assign w_step = !wen_n && wres_n;
  assign r_clr  = !rres_n;
  assign r_step = !ren_n && rres_n;

  lm_addr_ctr #(.DEPTH(DEPTH)) u_wptr (
    .clk(wclk), .clr(w_clr), .step(w_step), .ptr(w_ptr)
  );

  lm_addr_ctr #(.DEPTH(DEPTH)) u_r1ptr (
    .clk(rclk), .clr(r_clr), .step(r_step), .ptr(r1_ptr)
  );

  lm_addr_ctr #(.DEPTH(DEPTH)) u_r2ptr (
    .clk(rclk), .clr(r_clr), .step(r_step), .ptr(r2_ptr)
  );

  lm_copy_stage #(.AW(AW)) u_copy (
    .clk(rclk), .step(r_step), .rd_addr(r2_ptr),
    .we(copy_we), .waddr(copy_addr)
  );

  lm_sdp_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_line1 (
    .wr_clk(wclk), .wr_en(w_step), .wr_addr(w_ptr), .wr_data(din),
    .rd_clk(rclk), .rd_en(r_step), .rd_addr(r1_ptr), .rd_data(q1)
  );

  lm_sdp_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_line2 (
    .wr_clk(rclk), .wr_en(copy_we), .wr_addr(copy_addr), .wr_data(q1),
    .rd_clk(rclk), .rd_en(r_step), .rd_addr(r2_ptr), .rd_data(q2)
  );

  always_ff @(posedge rclk) begin
    out_vld <= r_step;
  end

  assign q1_oe = out_vld;
  assign q2_oe = out_vld;

endmodule

// File: rtl/lm_dual_line_delay_chk.sv
module lm_dual_line_delay_chk #(
  parameter int unsigned DEPTH = 5120,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          wclk,
  input logic          wen_n,
  input logic          wres_n,
  input logic          rclk,
  input logic          ren_n,
  input logic          rres_n,
  input logic          q1_oe,
  input logic          q2_oe,
  input logic [AW-1:0] w_ptr,
  input logic [AW-1:0] r1_ptr,
  input logic [AW-1:0] r2_ptr,
  input logic          copy_we,
  input logic [AW-1:0] copy_addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic w_armed = 1'b0;
  logic r_armed = 1'b0;

  always_ff @(posedge wclk) if (!wres_n) w_armed <= 1'b1;
  always_ff @(posedge rclk) if (!rres_n) r_armed <= 1'b1;

  assert_wptr_step_R1: assert property (@(posedge wclk) disable iff (!w_armed)
    (!wen_n && wres_n && w_ptr != LAST) |=> (w_ptr == $past(w_ptr) + 1'b1));

  assert_wptr_hold_R2: assert property (@(posedge wclk) disable iff (!w_armed)
    (wen_n && wres_n) |=> $stable(w_ptr));

  assert_wptr_zero_R3: assert property (@(posedge wclk) disable iff (!w_armed)
    !wres_n |=> (w_ptr == '0));

  assert_rptr_match_R4: assert property (@(posedge rclk) disable iff (!r_armed)
    r1_ptr == r2_ptr);

  assert_oe_after_read_R4: assert property (@(posedge rclk) disable iff (!r_armed)
    (!ren_n && rres_n) |=> (q1_oe && q2_oe));

  assert_copy_follows_R5: assert property (@(posedge rclk) disable iff (!r_armed)
    (!ren_n && rres_n) |=> (copy_we && copy_addr == $past(r1_ptr)));

  assert_idle_hold_R6: assert property (@(posedge rclk) disable iff (!r_armed)
    (ren_n && rres_n) |=> (!q1_oe && !q2_oe && $stable(r1_ptr) && !copy_we));

  assert_rres_zero_R7: assert property (@(posedge rclk) disable iff (!r_armed)
    !rres_n |=> (r1_ptr == '0 && !q1_oe && !q2_oe));

  assert_wptr_wrap_R8: assert property (@(posedge wclk) disable iff (!w_armed)
    (!wen_n && wres_n && w_ptr == LAST) |=> (w_ptr == '0));

  assert_rptr_wrap_R8: assert property (@(posedge rclk) disable iff (!r_armed)
    (!ren_n && rres_n && r1_ptr == LAST) |=> (r1_ptr == '0));

endmodule

bind lm_dual_line_delay lm_dual_line_delay_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .wen_n(wen_n), .wres_n(wres_n),
  .rclk(rclk), .ren_n(ren_n), .rres_n(rres_n),
  .q1_oe(q1_oe), .q2_oe(q2_oe),
  .w_ptr(w_ptr), .r1_ptr(r1_ptr), .r2_ptr(r2_ptr),
  .copy_we(copy_we), .copy_addr(copy_addr)
);

// File: tb/lm_dual_line_delay_tb.sv
module lm_dual_line_delay_tb;

  localparam int unsigned DEPTH = 5120;
  localparam int unsigned WIDTH = 8;

  logic             wclk = 1'b0, rclk = 1'b0;
  logic             wen_n = 1'b1, wres_n = 1'b1, ren_n = 1'b1, rres_n = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] q1, q2;
  logic             q1_oe, q2_oe;

  int checks = 0;
  int failures = 0;

  // Abstract model of the stores, built from the requirements.
  logic [WIDTH-1:0] m1 [DEPTH];
  logic [WIDTH-1:0] m2 [DEPTH];
  bit               m1v [DEPTH];
  bit               m2v [DEPTH];
  int unsigned      wp = 0, rp = 0;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  lm_dual_line_delay #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .wclk(wclk), .wen_n(wen_n), .wres_n(wres_n), .din(din),
    .rclk(rclk), .ren_n(ren_n), .rres_n(rres_n),
    .q1(q1), .q1_oe(q1_oe), .q2(q2), .q2_oe(q2_oe)
  );

  function automatic int unsigned nxt(input int unsigned a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cycle(input bit en, input bit rst, input logic [WIDTH-1:0] d);
    @(negedge wclk);
    wen_n = !en; wres_n = !rst; din = d;
    @(posedge wclk);
    if (rst) wp = 0;
    else if (en) begin
      m1[wp] = d; m1v[wp] = 1'b1; wp = nxt(wp);
    end
  endtask

  task automatic rd_cycle(input bit en, input bit rst, input string tag);
    logic [WIDTH-1:0] e1, e2;
    bit v1, v2, eo;
    e1 = '0; e2 = '0; v1 = 0; v2 = 0; eo = 0;
    @(negedge rclk);
    ren_n = !en; rres_n = !rst;
    @(posedge rclk);
    if (rst) rp = 0;
    else if (en) begin
      e1 = m1[rp]; v1 = m1v[rp]; e2 = m2[rp]; v2 = m2v[rp];
      m2[rp] = e1; m2v[rp] = v1; rp = nxt(rp); eo = 1;
    end
    #1;
    chk(q1_oe == eo && q2_oe == eo, tag, {q1_oe, q2_oe}, {eo, eo});
    if (eo && v1) chk(q1 == e1, tag, q1, e1);
    if (eo && v2) chk(q2 == e2, tag, q2, e2);
  endtask

  task automatic write_line(input int len, input logic [WIDTH-1:0] seed, input bit gaps);
    wr_cycle(1, 1, 8'hEE);            // reset wins over enable (R3)
    for (int i = 0; i < len; i++) begin
      wr_cycle(1, 0, seed + WIDTH'(i * 7));
      if (gaps) wr_cycle(0, 0, 8'hA5 ^ WIDTH'(i));   // not stored (R2)
    end
    wr_cycle(0, 0, 8'h00);
  endtask

  task automatic read_line(input int len, input string tag, input bit gaps);
    rd_cycle(1, 1, "R7");
    for (int i = 0; i < len; i++) begin
      rd_cycle(1, 0, tag);
      if (gaps && (i % 3 == 1)) rd_cycle(0, 0, "R6");
    end
    rd_cycle(0, 0, "R6");
  endtask

  task automatic t_reset;
    wr_cycle(0, 1, 8'h00);
    rd_cycle(1, 1, "R7");             // reset with enable low: no read
    rd_cycle(0, 0, "R6");
  endtask

  task automatic t_lines;
    for (int n = 0; n < 4; n++) begin
      write_line(10, WIDTH'(n * 16 + 3), 0);
      read_line(10, "R1/R4/R5", 0);
    end
  endtask

  task automatic t_wen_hold;
    write_line(9, 8'h40, 1);
    read_line(9, "R2/R5", 0);
    write_line(9, 8'h90, 0);
    read_line(9, "R2/R5", 0);
  endtask

  task automatic t_ren_hold;
    write_line(8, 8'h11, 0);
    read_line(8, "R6/R4", 1);
    write_line(8, 8'h77, 0);
    read_line(8, "R6/R5", 1);
  endtask

  task automatic t_wres_mid;
    write_line(6, 8'h20, 0);
    wr_cycle(0, 1, 8'hCC);
    for (int i = 0; i < 3; i++) wr_cycle(1, 0, 8'hD0 + WIDTH'(i));
    wr_cycle(0, 0, 8'h00);
    read_line(6, "R3", 0);
    // read reset mid-line restarts both stores at 0
    rd_cycle(1, 1, "R7");
    rd_cycle(1, 0, "R7");
    rd_cycle(1, 0, "R7");
    rd_cycle(1, 1, "R7");
    for (int i = 0; i < 6; i++) rd_cycle(1, 0, "R7/R5");
    rd_cycle(0, 0, "R6");
  endtask

  task automatic t_wrap;
    wr_cycle(1, 1, 8'h00);
    for (int i = 0; i < DEPTH + 3; i++) wr_cycle(1, 0, WIDTH'(i) ^ 8'h5A);
    wr_cycle(0, 0, 8'h00);
    read_line(DEPTH + 3, "R8", 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m1v[i] = 0; m2v[i] = 0; m1[i] = '0; m2[i] = '0;
    end
    t_reset();
    t_lines();
    t_wen_hold();
    t_ren_hold();
    t_wres_mid();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule